// File: doc/BRIEF.md
# Sound Bus Register Decoder with Boot-ROM Overlay

This block decodes the CPU bus of a 64 KiB sound-processor address space. Each access goes to one of four places: the external RAM, a 64-byte boot ROM overlaid on the top of memory, a small register page near the bottom of memory, or an audio DSP. The DSP is reached indirectly. An index latch selects one DSP register, and a data port reads or writes that register.

Reads are combinational. `busRdData` follows `busAddr` in the same cycle. Writes take effect on the rising clock edge while `busWrEn` is high. A write anywhere in the ROM window always lands in the RAM underneath it, so clearing the overlay bit exposes whatever was last written there. Writes to the timer-related register addresses also raise a one-cycle select strobe for an external timer block.

Top module: `snd_bus_decoder`

## Requirements
- R1: After reset the ROM overlay is enabled and the DSP index latch reads 0x00 at address 0x00F2.
- R2: Any address outside the register page 0x00F0–0x00FF and outside the ROM window goes to RAM. `ramAddr` equals `busAddr`, a write raises `ramWrEn` with `ramWrData` equal to `busWrData`, and a read returns `ramRdData`.
- R3: While the overlay is enabled, a read in the ROM window 0xFFC0–0xFFFF returns byte `busAddr[5:0]` of the boot image. Byte n of the image is bits [8n+7:8n] of `BOOT_IMAGE`. The default image is all zeros except byte 62 = 0xC0 and byte 63 = 0xFF.
- R4: A write to 0x00F1 sets the overlay enable to data bit 7. With the overlay disabled, ROM-window reads return RAM data.
- R5: Every write in the ROM window raises `ramWrEn`, whatever the overlay state. The ROM contents never change.
- R6: 0x00F2 is a read/write index latch. Writing it updates the latch and does not raise `ramWrEn`.
- R7: A read of 0x00F3 returns `dspRdData`. `dspAddr` always equals the index latch with bit 7 dropped, so indices 0x80–0xFF mirror 0x00–0x7F.
- R8: A write to 0x00F3 raises `dspWrEn` with `dspWrData` equal to `busWrData` only when the index latch is below 0x80. Otherwise nothing is written. A write to 0x00F3 never raises `ramWrEn`.
- R9: Addresses 0x00F8 and 0x00F9 read and write as plain RAM, and writing them raises no timer strobe.
- R10: A write to 0x00F1 or to any of 0x00FA–0x00FF raises `tmrSel` for that cycle, with `tmrAddr = busAddr[3:0]` and `tmrData = busWrData`. No other access raises `tmrSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | CPU bus address |
| busWrEn | input | 1 | CPU write enable |
| busWrData | input | 8 | CPU write data |
| busRdData | output | 8 | CPU read data (combinational) |
| ramAddr | output | 16 | RAM address |
| ramWrEn | output | 1 | RAM write enable |
| ramWrData | output | 8 | RAM write data |
| ramRdData | input | 8 | RAM read data (combinational) |
| dspAddr | output | 7 | DSP register index |
| dspWrEn | output | 1 | DSP register write enable |
| dspWrData | output | 8 | DSP register write data |
| dspRdData | input | 8 | DSP register read data |
| tmrSel | output | 1 | Timer register write strobe |
| tmrAddr | output | 4 | Low address bits of the timer write |
| tmrData | output | 8 | Timer write data |

## Verification
Random full-range addresses exercise the RAM path. Random accesses biased toward the register page and the ROM window separate the decode of neighbouring registers, such as the plain cells 0x00F8/0x00F9 and the timer-strobe addresses. Index-latch values above 0x7F are mixed with values below it, so the mirroring of reads and the dropping of writes are told apart from straight forwarding. ROM-window writes made with the overlay enabled are read back after the overlay is cleared, which shows the write-through reached RAM. Reads with the overlay set again show the ROM bytes were left untouched.

// File: rtl/snd_bus_pkg.sv
package snd_bus_pkg;
  // Decode strobes passed from control to datapath
  typedef struct packed {
    logic romHit;   // address inside ROM window
    logic idxHit;   // index latch address
    logic dataHit;  // DSP data port address
    logic ctlWr;    // write to overlay control register
    logic idxWr;    // write to index latch
    logic dataWr;   // write to DSP data port
    logic ramWr;    // write lands in RAM
    logic tmrWr;    // write is forwarded to timer block
  } busStrb_t;
endpackage

// File: rtl/snd_bus_ctrl.sv
module snd_bus_ctrl
  import snd_bus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ROM_AW = 6,
  parameter logic [ADDR_W-1:0] PAGE_BASE = 16'h00F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output busStrb_t          strb
);
  localparam logic [3:0] OFF_CTL  = 4'h1;
  localparam logic [3:0] OFF_IDX  = 4'h2;
  localparam logic [3:0] OFF_DATA = 4'h3;
  localparam logic [3:0] OFF_TMR0 = 4'hA;

  logic       pageHit;
  logic [3:0] pageOff;

  assign pageHit = (busAddr[ADDR_W-1:4] == PAGE_BASE[ADDR_W-1:4]);
  assign pageOff = busAddr[3:0];

  always_comb begin
    strb         = '0;
    strb.romHit  = &busAddr[ADDR_W-1:ROM_AW];
    strb.idxHit  = pageHit && (pageOff == OFF_IDX);
    strb.dataHit = pageHit && (pageOff == OFF_DATA);
    strb.ctlWr   = busWrEn && pageHit && (pageOff == OFF_CTL);
    strb.idxWr   = busWrEn && strb.idxHit;
    strb.dataWr  = busWrEn && strb.dataHit;
    strb.ramWr   = busWrEn && !strb.idxHit && !strb.dataHit;
    strb.tmrWr   = busWrEn && pageHit &&
                   ((pageOff == OFF_CTL) || (pageOff >= OFF_TMR0));
  end

  // R6/R8: latch and DSP-port writes never reach RAM
  a_r6_no_ram_on_port: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.idxWr || strb.dataWr) |-> !strb.ramWr);
  // R10: timer strobe only accompanies a write that also updates RAM
  a_r10_tmr_with_ram: assert property (@(posedge clk) disable iff (!rst_n)
    strb.tmrWr |-> (strb.ramWr && !strb.romHit));
endmodule

// File: rtl/snd_bus_dp.sv
module snd_bus_dp
  import snd_bus_pkg::*;
#(
  parameter int ROM_AW = 6,
  parameter logic [(2**ROM_AW)*8-1:0] BOOT_IMAGE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  busStrb_t          strb,
  input  logic [ROM_AW-1:0] romOff,
  input  logic [7:0]        busWrData,
  input  logic [7:0]        ramRdData,
  input  logic [7:0]        dspRdData,
  output logic [7:0]        busRdData,
  output logic [6:0]        dspAddr,
  output logic              dspWrEn
);
  localparam int ROM_BYTES = 2**ROM_AW;

  logic       romOn;
  logic [7:0] idxReg;
  logic [7:0] romByte [ROM_BYTES];

  for (genvar g = 0; g < ROM_BYTES; g++) begin : g_rom
    assign romByte[g] = BOOT_IMAGE[g*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      romOn  <= 1'b1;
      idxReg <= 8'h00;
    end else begin
      if (strb.ctlWr) romOn  <= busWrData[7];
      if (strb.idxWr) idxReg <= busWrData;
    end
  end

  assign dspAddr = idxReg[6:0];
  assign dspWrEn = strb.dataWr && !idxReg[7];

  always_comb begin
    if (strb.idxHit)                busRdData = idxReg;
    else if (strb.dataHit)          busRdData = dspRdData;
    else if (strb.romHit && romOn)  busRdData = romByte[romOff];
    else                            busRdData = ramRdData;
  end

  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (romOn && idxReg == 8'h00));
  // R6: latch holds unless written
  a_r6_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.idxWr |=> $stable(idxReg));
  // R4: overlay follows bit 7 of a control write
  a_r4_overlay_update: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ctlWr |=> (romOn == $past(busWrData[7])));
  // R8: high indices never produce a DSP write
  a_r8_drop_high: assert property (@(posedge clk) disable iff (!rst_n)
    dspWrEn |-> (strb.dataWr && idxReg < 8'h80));
endmodule

// File: rtl/snd_bus_decoder.sv
module snd_bus_decoder
  import snd_bus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ROM_AW = 6,
  parameter logic [ADDR_W-1:0] PAGE_BASE = 16'h00F0,
  parameter logic [(2**ROM_AW)*8-1:0] BOOT_IMAGE =
    {8'hFF, 8'hC0, {((2**ROM_AW)-2)*8{1'b0}}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWrEn,
  output logic [7:0]        ramWrData,
  input  logic [7:0]        ramRdData,
  output logic [6:0]        dspAddr,
  output logic              dspWrEn,
  output logic [7:0]        dspWrData,
  input  logic [7:0]        dspRdData,
  output logic              tmrSel,
  output logic [3:0]        tmrAddr,
  output logic [7:0]        tmrData
);
  busStrb_t strb;

  snd_bus_ctrl #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW), .PAGE_BASE(PAGE_BASE)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn), .strb(strb)
  );

  snd_bus_dp #(.ROM_AW(ROM_AW), .BOOT_IMAGE(BOOT_IMAGE)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .romOff(busAddr[ROM_AW-1:0]),
    .busWrData(busWrData), .ramRdData(ramRdData), .dspRdData(dspRdData),
    .busRdData(busRdData), .dspAddr(dspAddr), .dspWrEn(dspWrEn)
  );

  assign ramAddr   = busAddr;
  assign ramWrEn   = strb.ramWr;
  assign ramWrData = busWrData;
  assign dspWrData = busWrData;
  assign tmrSel    = strb.tmrWr;
  assign tmrAddr   = busAddr[3:0];
  assign tmrData   = busWrData;

  // R5: ROM-window writes always reach RAM
  a_r5_rom_write_through: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && (&busAddr[ADDR_W-1:ROM_AW])) |-> ramWrEn);
  // R10: strobe only with a bus write
  a_r10_strobe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    tmrSel |-> (busWrEn && tmrData == busWrData));
endmodule

// File: tb/snd_bus_decoder_tb.sv
module snd_bus_decoder_tb_top;
  function automatic logic [511:0] mkImg();
    logic [511:0] img;
    for (int i = 0; i < 62; i++) img[i*8 +: 8] = 8'((i * 7) + 3);
    img[62*8 +: 8] = 8'hC0;
    img[63*8 +: 8] = 8'hFF;
    return img;
  endfunction
  localparam logic [511:0] IMG = mkImg();

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] busAddr = '0; logic busWrEn = 1'b0; logic [7:0] busWrData = '0;
  logic [7:0] busRdData, ramWrData, ramRdData, dspWrData, dspRdData, tmrData;
  logic [15:0] ramAddr; logic ramWrEn, dspWrEn, tmrSel;
  logic [6:0] dspAddr; logic [3:0] tmrAddr;

  logic [7:0] memArr [65536];
  logic [7:0] dspArr [128];
  logic [7:0] memM [65536];
  logic [7:0] dspM [128];
  logic [7:0] idxM; logic romOnM;
  int vecs = 0, bad = 0;

  always #4 clk = ~clk;

  snd_bus_decoder #(.BOOT_IMAGE(IMG)) dut_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .ramAddr(ramAddr),
    .ramWrEn(ramWrEn), .ramWrData(ramWrData), .ramRdData(ramRdData),
    .dspAddr(dspAddr), .dspWrEn(dspWrEn), .dspWrData(dspWrData),
    .dspRdData(dspRdData), .tmrSel(tmrSel), .tmrAddr(tmrAddr), .tmrData(tmrData)
  );

  assign ramRdData = memArr[ramAddr];
  assign dspRdData = dspArr[dspAddr];
  always @(posedge clk) begin
    if (ramWrEn) memArr[ramAddr] <= ramWrData;
    if (dspWrEn) dspArr[dspAddr] <= dspWrData;
  end

  function automatic logic [7:0] expRead(logic [15:0] a);
    if (a == 16'h00F2) return idxM;
    if (a == 16'h00F3) return dspM[idxM[6:0]];
    if (a >= 16'hFFC0 && romOnM) return IMG[a[5:0]*8 +: 8];
    return memM[a];
  endfunction
  function automatic logic expTmr(logic [15:0] a);
    return (a == 16'h00F1) || (a >= 16'h00FA && a <= 16'h00FF);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(logic [15:0] a, string req);
    @(negedge clk); busAddr = a; busWrEn = 1'b0; #2;
    check(req, busRdData, expRead(a));
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d, string req);
    logic ramE, dspE;
    @(negedge clk); busAddr = a; busWrData = d; busWrEn = 1'b1; #2;
    ramE = (a != 16'h00F2) && (a != 16'h00F3);
    dspE = (a == 16'h00F3) && !idxM[7];
    check({req, " ramWrEn"}, ramWrEn, ramE);
    check({req, " dspWrEn"}, dspWrEn, dspE);
    check({req, " tmrSel"}, tmrSel, expTmr(a));
    if (expTmr(a)) check({req, " tmrAddr/Data"}, {tmrAddr, tmrData}, {a[3:0], d});
    if (dspE) check({req, " dspAddr"}, dspAddr, idxM[6:0]);
    if (a == 16'h00F2) idxM = d;
    else if (a == 16'h00F3) begin if (dspE) dspM[idxM[6:0]] = d; end
    else memM[a] = d;
    if (a == 16'h00F1) romOnM = d[7];
    @(negedge clk); busWrEn = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 65536; i++) begin memArr[i] = 8'(i ^ (i >> 8)); memM[i] = 8'(i ^ (i >> 8)); end
    for (int i = 0; i < 128; i++) begin dspArr[i] = 8'(i + 8'h40); dspM[i] = 8'(i + 8'h40); end
    idxM = 8'h00; romOnM = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(16'h00F2, "R1 idx reset");
    rd(16'hFFFE, "R1/R3 rom byte 62");
    rd(16'hFFFF, "R3 rom byte 63");
    rd(16'hFFC0, "R3 rom byte 0");
    // R5 write-through under visible ROM
    wr(16'hFFC5, 8'hA7, "R5 rom window write");
    rd(16'hFFC5, "R5 rom unchanged");
    wr(16'h00F1, 8'h00, "R4 overlay off");
    rd(16'hFFC5, "R4/R5 shadow visible");
    wr(16'h00F1, 8'h80, "R4 overlay on");
    rd(16'hFFC5, "R4 rom back");
    // R7/R8 mirror and drop
    wr(16'h00F2, 8'h85, "R6 idx high");
    rd(16'h00F2, "R6 idx readback");
    rd(16'h00F3, "R7 mirrored read");
    wr(16'h00F3, 8'h3C, "R8 dropped write");
    wr(16'h00F2, 8'h05, "R6 idx low");
    rd(16'h00F3, "R8 entry untouched");
    wr(16'h00F3, 8'h3C, "R8 forwarded write");
    rd(16'h00F3, "R8 readback");
    // R9 plain cells
    wr(16'h00F8, 8'h11, "R9 F8");
    wr(16'h00F9, 8'h22, "R9 F9");
    rd(16'h00F8, "R9 F8 read");
    rd(16'h00F9, "R9 F9 read");
    // R10 timer registers
    for (int a = 16'h00FA; a <= 16'h00FF; a++) wr(16'(a), 8'(a * 3), "R10 timer write");
    // Mixed random traffic
    for (int n = 0; n < 1500; n++) begin
      logic [15:0] a;
      logic [1:0] kind;
      kind = 2'($urandom_range(0, 3));
      case (kind)
        2'd0: a = 16'($urandom);
        2'd1: a = 16'h00F0 | 16'($urandom_range(0, 15));
        2'd2: a = 16'hFFC0 | 16'($urandom_range(0, 63));
        default: a = 16'($urandom_range(16'h00E0, 16'h010F));
      endcase
      if ($urandom_range(0, 1) == 1) wr(a, 8'($urandom), "R2/R10 random write");
      else rd(a, "R2/R3/R7 random read");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule